// File: doc/BRIEF.md
# BCD time-of-day register file

This block is the counting and register core of a calendar clock. A free-running tick input is divided by a parameterised prescaler into whole seconds, and each second steps a calendar of seconds, minutes, hours, weekday, day of month, month and two-digit year, with carries propagated all the way up. Software sees ten byte-wide registers through a single-cycle write strobe and a combinational read path. All time fields are presented in BCD.

Writes are checked field by field. A value that is out of range for its field is dropped and the old contents stay in place. The seconds register also carries a stop bit that freezes the clock, so time can be set field by field without racing the carry chain. The day register holds a spare century flag beside the weekday. A control byte is kept with some bits forced to fixed values. A flags location and an unused location both read as zero. Register indices: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year, 8 flags, 9 unused.

Top module: `bcd_tod_regs`

## Requirements
- R1: After reset the registers read 0x90 at control (index 0), 0x00 at seconds (index 1), minutes (2), hours (3), day (4) and year (7), and 0x01 at date (5) and month (6). The stop bit is clear.
- R2: While running, the seconds advance by one on every PRESCALE-th tick pulse. Seconds 59 wraps to 0 and carries into minutes. Minutes 59 carries into hours. Hours 23 carries into the day change. Month 12 carries into the year, and year 99 wraps to 00.
- R3: Bit 7 of seconds (index 1) is the stop bit. While it is 1, neither the time nor the tick prescaler advances, and clearing it resumes counting. A seconds read returns the stop bit in bit 7 and the BCD seconds in bits 6:0.
- R4: A seconds or minutes write decodes the low 7 bits as BCD (upper nibble times ten plus lower nibble) and is kept only if the result is 0 to 59. An hours write decodes the low 6 bits and is kept only if the result is 0 to 23. A rejected value leaves the field unchanged. A seconds write always loads the stop bit from data bit 7.
- R5: A date write (index 5) decodes the low 6 bits and is dropped if the result is zero. A month write (index 6) decodes the low 5 bits and is kept only for 1 to 12. A year write (index 7) decodes all 8 bits and is kept only for 0 to 99.
- R6: A day write (index 4) always loads the weekday from data bits 2:0 and the century flag from bit 6. A day read returns the century flag in bit 6 and the weekday in bits 2:0, with every other bit zero.
- R7: A control write (index 0) stores the data with bits 7 and 4 set to 1 and bit 5 cleared. All other bits are kept as written.
- R8: Writes to flags (index 8) have no effect. Flags, unused (index 9) and indices 10 to 15 read 0x00.
- R9: At a day change the date wraps to 1 once it has reached the month length and the month advances. The month length is 30 days for months 4, 6, 9 and 11, and 31 days for the others. February has 29 days when the binary year is divisible by 4 and 28 otherwise. A written date above the month length wraps at the next day change.
- R10: The weekday advances at each day change, and a weekday of 6 or 7 becomes 0.
- R11: A write takes effect at the clock edge that samples it and does not reset the prescaler count. A second that falls due in the same cycle as a write to any time field (indices 1 to 7) is applied one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse; PRESCALE pulses make one second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | AW | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
On every cycle, the assertions check that the stored fields stay in their legal ranges whatever is written. They also check that the state does not move while the stop bit is held, that the seconds read shows the stop bit, that the forced control bits are visible, that the zero locations read zero, and that the seconds and weekday step correctly. Only the bench's scenarios can show the exact acceptance boundary of each write decode. That needs a sweep of every byte value per register. The same holds for month-length and leap-year rollover across every month, the year wrap, the preserved prescaler phase, and the deferral of a second that collides with a write.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;

   localparam int IDX_CTRL   = 0;
   localparam int IDX_SEC    = 1;
   localparam int IDX_MIN    = 2;
   localparam int IDX_HR     = 3;
   localparam int IDX_DAY    = 4;
   localparam int IDX_DATE   = 5;
   localparam int IDX_MON    = 6;
   localparam int IDX_YR     = 7;
   localparam int IDX_FLAG   = 8;
   localparam int IDX_UNUSED = 9;

   localparam logic [7:0] CTRL_RESET = 8'h90;

   // Calendar state, fields held in binary
   typedef struct packed {
      logic       stop;
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hr;
      logic [2:0] wday;
      logic       cent;
      logic [5:0] date;
      logic [3:0] mon;
      logic [6:0] yr;
   } tod_t;

   // Decoded write request
   typedef struct packed {
      logic       time_we;
      logic       stop_we;
      logic       stop;
      logic       sec_we;
      logic [5:0] sec;
      logic       min_we;
      logic [5:0] min;
      logic       hr_we;
      logic [4:0] hr;
      logic       day_we;
      logic [2:0] wday;
      logic       cent;
      logic       date_we;
      logic [5:0] date;
      logic       mon_we;
      logic [3:0] mon;
      logic       yr_we;
      logic [6:0] yr;
      logic       ctrl_we;
      logic [7:0] ctrl;
   } tod_wr_t;

   function automatic logic [7:0] bcd2bin(input logic [7:0] b);
      return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [6:0] v);
      logic [7:0] w;
      w = {1'b0, v};
      return ((w / 8'd10) << 4) | (w % 8'd10);
   endfunction

   function automatic logic [5:0] month_days(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd4, 4'd6, 4'd9, 4'd11: return 6'd30;
         4'd2:                    return leap ? 6'd29 : 6'd28;
         default:                 return 6'd31;
      endcase
   endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic sec_pulse
);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("tod_prescaler: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign sec_pulse = tick && run;
   end else begin : g_count
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (tick && run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
         end
      end

      assign sec_pulse = tick && run && (cnt_q == LAST);
   end

endmodule

// File: rtl/tod_write_decode.sv
module tod_write_decode
   import bcd_tod_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output tod_wr_t       wr
);

   logic [7:0] d_sec, d_min, d_hr, d_date, d_mon, d_yr;
   logic       hit_sec, hit_min, hit_hr, hit_day, hit_date, hit_mon, hit_yr, hit_ctrl;

   always_comb begin
      hit_ctrl = wr_en && (addr == AW'(IDX_CTRL));
      hit_sec  = wr_en && (addr == AW'(IDX_SEC));
      hit_min  = wr_en && (addr == AW'(IDX_MIN));
      hit_hr   = wr_en && (addr == AW'(IDX_HR));
      hit_day  = wr_en && (addr == AW'(IDX_DAY));
      hit_date = wr_en && (addr == AW'(IDX_DATE));
      hit_mon  = wr_en && (addr == AW'(IDX_MON));
      hit_yr   = wr_en && (addr == AW'(IDX_YR));

      d_sec  = bcd2bin({1'b0, wdata[6:0]});
      d_min  = bcd2bin({1'b0, wdata[6:0]});
      d_hr   = bcd2bin({2'b0, wdata[5:0]});
      d_date = bcd2bin({2'b0, wdata[5:0]});
      d_mon  = bcd2bin({3'b0, wdata[4:0]});
      d_yr   = bcd2bin(wdata);

      wr.time_we = hit_sec | hit_min | hit_hr | hit_day | hit_date | hit_mon | hit_yr;
      wr.stop_we = hit_sec;
      wr.stop    = wdata[7];
      wr.sec_we  = hit_sec && (d_sec <= 8'd59);
      wr.sec     = d_sec[5:0];
      wr.min_we  = hit_min && (d_min <= 8'd59);
      wr.min     = d_min[5:0];
      wr.hr_we   = hit_hr && (d_hr <= 8'd23);
      wr.hr      = d_hr[4:0];
      wr.day_we  = hit_day;
      wr.wday    = wdata[2:0];
      wr.cent    = wdata[6];
      wr.date_we = hit_date && (d_date != 8'd0);
      wr.date    = d_date[5:0];
      wr.mon_we  = hit_mon && (d_mon >= 8'd1) && (d_mon <= 8'd12);
      wr.mon     = d_mon[3:0];
      wr.yr_we   = hit_yr && (d_yr <= 8'd99);
      wr.yr      = d_yr[6:0];
      wr.ctrl_we = hit_ctrl;
      wr.ctrl    = (wdata & 8'h5F) | 8'h90;
   end

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
   import bcd_tod_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sec_pulse,
   input  tod_wr_t wr,
   output tod_t    st,
   output logic [7:0] ctrl,
   output logic    adv
);

   tod_t       q, n;
   logic [7:0] ctrl_q;
   logic       pend_q, due, pend_d;
   logic       leap;

   always_comb begin
      due    = pend_q | sec_pulse;
      adv    = due && !wr.time_we && !q.stop;
      pend_d = due && wr.time_we && !q.stop;
   end

   always_comb begin
      n    = q;
      leap = (q.yr[1:0] == 2'b00);
      if (adv) begin
         if (q.sec != 6'd59) begin
            n.sec = q.sec + 6'd1;
         end else begin
            n.sec = '0;
            if (q.min != 6'd59) begin
               n.min = q.min + 6'd1;
            end else begin
               n.min = '0;
               if (q.hr != 5'd23) begin
                  n.hr = q.hr + 5'd1;
               end else begin
                  n.hr   = '0;
                  n.wday = (q.wday >= 3'd6) ? 3'd0 : q.wday + 3'd1;
                  if (q.date < month_days(q.mon, leap)) begin
                     n.date = q.date + 6'd1;
                  end else begin
                     n.date = 6'd1;
                     if (q.mon < 4'd12) begin
                        n.mon = q.mon + 4'd1;
                     end else begin
                        n.mon = 4'd1;
                        n.yr  = (q.yr == 7'd99) ? 7'd0 : q.yr + 7'd1;
                     end
                  end
               end
            end
         end
      end
      if (wr.stop_we) n.stop = wr.stop;
      if (wr.sec_we)  n.sec  = wr.sec;
      if (wr.min_we)  n.min  = wr.min;
      if (wr.hr_we)   n.hr   = wr.hr;
      if (wr.day_we) begin
         n.wday = wr.wday;
         n.cent = wr.cent;
      end
      if (wr.date_we) n.date = wr.date;
      if (wr.mon_we)  n.mon  = wr.mon;
      if (wr.yr_we)   n.yr   = wr.yr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '{stop: 1'b0, sec: '0, min: '0, hr: '0, wday: '0, cent: 1'b0,
                     date: 6'd1, mon: 4'd1, yr: '0};
         ctrl_q <= CTRL_RESET;
         pend_q <= 1'b0;
      end else begin
         q      <= n;
         pend_q <= pend_d;
         if (wr.ctrl_we) ctrl_q <= wr.ctrl;
      end
   end

   assign st   = q;
   assign ctrl = ctrl_q;

endmodule

// File: rtl/tod_read_mux.sv
module tod_read_mux
   import bcd_tod_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic [AW-1:0] addr,
   input  tod_t          st,
   input  logic [7:0]    ctrl,
   output logic [7:0]    rdata
);

   always_comb begin
      rdata = 8'h00;
      case (addr)
         AW'(IDX_CTRL): rdata = ctrl;
         AW'(IDX_SEC):  rdata = {st.stop, 7'(bin2bcd({1'b0, st.sec}))};
         AW'(IDX_MIN):  rdata = bin2bcd({1'b0, st.min});
         AW'(IDX_HR):   rdata = bin2bcd({2'b0, st.hr});
         AW'(IDX_DAY):  rdata = {1'b0, st.cent, 3'b000, st.wday};
         AW'(IDX_DATE): rdata = bin2bcd({1'b0, st.date});
         AW'(IDX_MON):  rdata = bin2bcd({3'b0, st.mon});
         AW'(IDX_YR):   rdata = bin2bcd(st.yr);
         default:       rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/bcd_tod_regs.sv
module bcd_tod_regs
   import bcd_tod_pkg::*;
#(
   parameter int PRESCALE = 4,
   parameter int AW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   if (AW < 4) begin : g_bad_aw
      $error("bcd_tod_regs: AW must cover ten register indices");
   end

   tod_wr_t    wr_req;
   tod_t       cal_state;
   logic [7:0] cal_ctrl;
   logic       cal_adv;
   logic       sec_pulse;

   tod_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .run       (!cal_state.stop),
      .sec_pulse (sec_pulse)
   );

   tod_write_decode #(.AW(AW)) u_decode (
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .wr    (wr_req)
   );

   tod_calendar u_calendar (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_pulse (sec_pulse),
      .wr        (wr_req),
      .st        (cal_state),
      .ctrl      (cal_ctrl),
      .adv       (cal_adv)
   );

   tod_read_mux #(.AW(AW)) u_rmux (
      .addr  (addr),
      .st    (cal_state),
      .ctrl  (cal_ctrl),
      .rdata (rdata)
   );

endmodule

// File: rtl/bcd_tod_regs_chk.sv
module bcd_tod_regs_chk
   import bcd_tod_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] addr,
   input logic [7:0]    rdata,
   input tod_t          st,
   input logic          adv
);

   // R3: a stopped clock with no write keeps every field
   a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st.stop) && !$past(wr_en)) |-> $stable(st));

   // R3: stop bit visible in seconds read
   a_r3_stop_read: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(IDX_SEC)) |-> (rdata[7] == st.stop));

   // R4: time fields stay in range
   a_r4_time_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st.sec <= 6'd59) && (st.min <= 6'd59) && (st.hr <= 5'd23));

   // R5: calendar fields stay in range
   a_r5_cal_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st.mon >= 4'd1) && (st.mon <= 4'd12) && (st.yr <= 7'd99) && (st.date != 6'd0));

   // R7: forced control bits
   a_r7_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(IDX_CTRL)) |-> (rdata[7] && rdata[4] && !rdata[5]));

   // R8: zero locations
   a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= AW'(IDX_FLAG)) |-> (rdata == 8'h00));

   // R2: a step below 59 adds one second
   a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && ($past(st.sec) != 6'd59)) |-> (st.sec == $past(st.sec) + 6'd1));

   // R10: weekday moves at the day change
   a_r10_weekday: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && ($past(st.hr) == 5'd23) && ($past(st.min) == 6'd59) &&
       ($past(st.sec) == 6'd59))
      |-> (st.wday == (($past(st.wday) >= 3'd6) ? 3'd0 : $past(st.wday) + 3'd1)));

endmodule

bind bcd_tod_regs bcd_tod_regs_chk #(.AW(AW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .rdata (rdata),
   .st    (cal_state),
   .adv   (cal_adv)
);

// File: tb/bcd_tod_regs_bench.sv
module bcd_tod_regs_bench;

   localparam int P  = 2;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;

   int n_chk = 0;
   int n_err = 0;

   // reference model, binary fields
   int e_sec, e_min, e_hr, e_wd, e_cen, e_date, e_mon, e_yr, e_stop, e_ctrl, e_ph;

   always #5 clk = ~clk;

   bcd_tod_regs #(.PRESCALE(P), .AW(AW)) u_bcd_tod_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   function automatic int fbcd(int v);
      return ((v >> 4) & 15) * 10 + (v & 15);
   endfunction

   function automatic int tbcd(int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   function automatic int dimf(int m, int y);
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      return 31;
   endfunction

   function automatic logic [7:0] exp_read(int idx);
      case (idx)
         0: return 8'(e_ctrl);
         1: return 8'((e_stop << 7) | tbcd(e_sec));
         2: return 8'(tbcd(e_min));
         3: return 8'(tbcd(e_hr));
         4: return 8'((e_cen << 6) | e_wd);
         5: return 8'(tbcd(e_date));
         6: return 8'(tbcd(e_mon));
         7: return 8'(tbcd(e_yr));
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_adv();
      if (e_sec != 59) e_sec++;
      else begin
         e_sec = 0;
         if (e_min != 59) e_min++;
         else begin
            e_min = 0;
            if (e_hr != 23) e_hr++;
            else begin
               e_hr = 0;
               e_wd = (e_wd >= 6) ? 0 : e_wd + 1;
               if (e_date < dimf(e_mon, e_yr)) e_date++;
               else begin
                  e_date = 1;
                  if (e_mon < 12) e_mon++;
                  else begin
                     e_mon = 1;
                     e_yr  = (e_yr == 99) ? 0 : e_yr + 1;
                  end
               end
            end
         end
      end
   endtask

   task automatic model_write(int idx, int v);
      int d;
      case (idx)
         0: e_ctrl = (v & 8'h5F) | 8'h90;
         1: begin d = fbcd(v & 8'h7F); if (d <= 59) e_sec = d; e_stop = (v >> 7) & 1; end
         2: begin d = fbcd(v & 8'h7F); if (d <= 59) e_min = d; end
         3: begin d = fbcd(v & 8'h3F); if (d <= 23) e_hr = d; end
         4: begin e_wd = v & 7; e_cen = (v >> 6) & 1; end
         5: begin d = fbcd(v & 8'h3F); if (d != 0) e_date = d; end
         6: begin d = fbcd(v & 8'h1F); if (d >= 1 && d <= 12) e_mon = d; end
         7: begin d = fbcd(v & 8'hFF); if (d <= 99) e_yr = d; end
         default: ;
      endcase
   endtask

   task automatic chk(string tag, int idx, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s reg %0d got %h exp %h", tag, idx, got, exp);
      end
   endtask

   task automatic rd_chk(string tag, int idx);
      @(negedge clk);
      addr = AW'(idx);
      #1;
      chk(tag, idx, rdata, exp_read(idx));
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < 10; i++) rd_chk(tag, i);
   endtask

   task automatic do_write(int idx, int v);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(idx); wdata = 8'(v);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      model_write(idx, v);
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      #1;
      tick = 1'b0;
      if (e_stop == 0) begin
         e_ph++;
         if (e_ph == P) begin
            e_ph = 0;
            model_adv();
         end
      end
   endtask

   task automatic step_secs(int n);
      for (int i = 0; i < n * P; i++) do_tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      e_sec = 0; e_min = 0; e_hr = 0; e_wd = 0; e_cen = 0; e_date = 1; e_mon = 1;
      e_yr = 0; e_stop = 0; e_ctrl = 8'h90; e_ph = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      check_all("R1");

      // R2 basic counting and carry
      do_write(3, 8'h22); do_write(2, 8'h59); do_write(1, 8'h58);
      step_secs(1);
      check_all("R2");
      step_secs(1);
      check_all("R2");

      // R4 full byte sweeps on seconds, minutes, hours
      for (int v = 0; v < 256; v++) begin do_write(1, v); rd_chk("R4", 1); end
      for (int v = 0; v < 256; v++) begin do_write(2, v); rd_chk("R4", 2); end
      for (int v = 0; v < 256; v++) begin do_write(3, v); rd_chk("R4", 3); end
      // R5 sweeps on date, month, year
      for (int v = 0; v < 256; v++) begin do_write(5, v); rd_chk("R5", 5); end
      for (int v = 0; v < 256; v++) begin do_write(6, v); rd_chk("R5", 6); end
      for (int v = 0; v < 256; v++) begin do_write(7, v); rd_chk("R5", 7); end
      // R6 day register
      for (int v = 0; v < 256; v++) begin do_write(4, v); rd_chk("R6", 4); end
      // R7 control
      for (int v = 0; v < 256; v++) begin do_write(0, v); rd_chk("R7", 0); end
      // R8 flags ignore writes; zero locations
      for (int v = 0; v < 256; v += 17) begin do_write(8, v); check_all("R8"); end
      for (int i = 10; i < 16; i++) rd_chk("R8", i);

      // R3 stop holds time and prescaler, then resumes
      do_write(1, 8'h95);
      for (int i = 0; i < 3 * P + 1; i++) do_tick();
      check_all("R3");
      do_write(1, 8'h15);
      step_secs(1);
      check_all("R3");

      // R9 / R10 month-end rollover for every month over several years
      foreach (e_ph_years[k]) begin end
      for (int yi = 0; yi < 4; yi++) begin
         for (int m = 1; m <= 12; m++) begin
            int y;
            y = (yi == 0) ? 0 : (yi == 1) ? 3 : (yi == 2) ? 4 : 99;
            do_write(7, tbcd(y));
            do_write(6, tbcd(m));
            do_write(5, tbcd(dimf(m, y)));
            do_write(4, ((m & 1) << 6) | (m & 7));
            do_write(3, 8'h23);
            do_write(2, 8'h59);
            do_write(1, 8'h59);
            step_secs(1);
            check_all("R9");
            rd_chk("R10", 4);
         end
      end
      // R9 date written above month length wraps at next day change
      do_write(6, 8'h04); do_write(5, 8'h45); do_write(3, 8'h23);
      do_write(2, 8'h59); do_write(1, 8'h59);
      step_secs(1);
      check_all("R9");

      // R11 prescaler phase survives a write
      while (e_ph != 1) do_tick();
      do_write(3, 8'h07);
      do_tick();
      check_all("R11");

      // R11 second due on the same cycle as a time write is applied a cycle later
      do_write(1, 8'h30);
      while (e_ph != P - 1) do_tick();
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = AW'(2); wdata = 8'h12;
      @(posedge clk);
      #1;
      tick = 1'b0; wr_en = 1'b0;
      e_ph = 0;
      model_write(2, 8'h12);
      rd_chk("R11", 1);
      model_adv();
      rd_chk("R11", 1);
      rd_chk("R11", 2);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   int e_ph_years[1];

endmodule